// File: doc/BRIEF.md
# Two-Tone Siren Square Wave Generator

This block turns an alarm enable into a one-bit audio square wave for an external speaker. While the enable is high, the output switches between a low tone and a high tone. The defaults are 400 Hz and 700 Hz from a 27 MHz clock. The tones alternate on a seconds-scale schedule, and that schedule is timed by a one-cycle pulse that arrives once per second.

Each tone is produced by a down-counter that reloads with a half-period count and flips the output at every reload. The dwell scheduler counts second pulses and asks for the other tone after every `DWELL_SECS` of them. The half-period counter takes up a new request only when it reloads. A half period is therefore never cut short, and a tone change never produces a runt pulse.

When the enable is low, the output is held at 0 and all phase state returns to its start values. The next activation then begins cleanly on the low tone.

Top module: `siren_tone_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `tone_out` is 0 after that edge.
- R2: After any clock edge at which `siren_on` is low, `tone_out` is 0. Second pulses seen while `siren_on` is low are ignored and do not count toward the next activation.
- R3: After activation, `tone_out` first rises after exactly `LOW_HALF` edges with `siren_on` high, so activation always starts on the low tone.
- R4: Every half period of `tone_out` lasts exactly the half-period count of the tone that was latched at the reload starting it. Only two lengths ever occur: `LOW_HALF` and `HIGH_HALF`.
- R5: The requested tone starts as low (encoding 0) at activation. It flips between low (0) and high (1) after every `DWELL_SECS`-th `sec_tick` that is sampled while `siren_on` is high. The pulse count restarts at every activation.
- R6: A new tone request takes effect only at the next half-period reload. Between reloads, `tone_out` does not change.
- R7: Each half-period count is CLK_HZ/(2·f) rounded to the nearest integer. With the defaults this gives 33,750 cycles for 400 Hz and 19,286 cycles for 700 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| siren_on | input | 1 | Alarm enable; the output is silent when low |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| tone_out | output | 1 | Registered square wave for the speaker |

## Verification
The bench builds the block with `CLK_HZ=40`, `LOW_HZ=4`, `HIGH_HZ=6` and `DWELL_SECS=2`, which gives half periods of 5 and 3 cycles. With counts this small, a sweep over pulse spacings from 1 to 7 cycles places a second pulse on every phase of both half periods. This covers a pulse landing exactly on a reload edge, pulses on consecutive cycles, and pulses arriving while the block is disabled. The bench derives the expected interval between output transitions from its own count of accepted pulses.

// File: rtl/siren_pkg.sv
package siren_pkg;

  typedef enum logic {
    TONE_LOW  = 1'b0,
    TONE_HIGH = 1'b1
  } tone_e;

  // Nearest-integer half-period count for a tone at tone_hz from clk_hz.
  function automatic int unsigned half_count(input int unsigned clk_hz,
                                             input int unsigned tone_hz);
    return (clk_hz + tone_hz) / (2 * tone_hz);
  endfunction

endpackage

// File: rtl/siren_dwell_sched.sv
module siren_dwell_sched
  import siren_pkg::*;
#(
  parameter int unsigned DWELL_SECS = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  sec_tick,
  output tone_e tone_req
);

  localparam int unsigned DW   = $clog2(DWELL_SECS + 1);
  localparam logic [DW-1:0] LAST = DW'(DWELL_SECS - 1);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      dcnt     <= '0;
      tone_req <= TONE_LOW;
    end else if (sec_tick) begin
      if (dcnt == LAST) begin
        dcnt     <= '0;
        tone_req <= (tone_req == TONE_LOW) ? TONE_HIGH : TONE_LOW;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  AST_DWELL_RANGE: assert property (@(posedge clk) disable iff (rst)
    dcnt < DW'(DWELL_SECS)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !sec_tick) |=> $stable(tone_req)); // R5
  AST_REQ_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tone_req == TONE_LOW)); // R5

endmodule

// File: rtl/siren_half_period.sv
module siren_half_period
  import siren_pkg::*;
#(
  parameter int unsigned LOW_HALF  = 33750,
  parameter int unsigned HIGH_HALF = 19286
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  tone_e tone_req,
  output logic  tone_out,
  output tone_e tone_active
);

  localparam int unsigned MAXH = (LOW_HALF > HIGH_HALF) ? LOW_HALF : HIGH_HALF;
  localparam int unsigned CW   = $clog2(MAXH + 1);
  localparam logic [CW-1:0] LOW_RL  = CW'(LOW_HALF - 1);
  localparam logic [CW-1:0] HIGH_RL = CW'(HIGH_HALF - 1);

  logic [CW-1:0] hcnt;

  function automatic logic [CW-1:0] reload_of(input tone_e t);
    return (t == TONE_HIGH) ? HIGH_RL : LOW_RL;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt        <= LOW_RL;
      tone_out    <= 1'b0;
      tone_active <= TONE_LOW;
    end else if (hcnt == '0) begin
      tone_out    <= ~tone_out;
      tone_active <= tone_req;
      hcnt        <= reload_of(tone_req);
    end else begin
      hcnt <= hcnt - 1'b1;
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tone_out); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    hcnt <= CW'(MAXH - 1)); // R4
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    (en && hcnt != '0) |=> ($stable(tone_out) && $stable(tone_active))); // R6

endmodule

// File: rtl/siren_tone_gen.sv
module siren_tone_gen
  import siren_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 27000000,
  parameter int unsigned LOW_HZ     = 400,
  parameter int unsigned HIGH_HZ    = 700,
  parameter int unsigned DWELL_SECS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic siren_on,
  input  logic sec_tick,
  output logic tone_out
);

  localparam int unsigned LOW_HALF  = half_count(CLK_HZ, LOW_HZ);
  localparam int unsigned HIGH_HALF = half_count(CLK_HZ, HIGH_HZ);

  tone_e tone_req;
  tone_e tone_active;

  siren_dwell_sched #(
    .DWELL_SECS(DWELL_SECS)
  ) sched_i (
    .clk      (clk),
    .rst      (rst),
    .en       (siren_on),
    .sec_tick (sec_tick),
    .tone_req (tone_req)
  );

  siren_half_period #(
    .LOW_HALF (LOW_HALF),
    .HIGH_HALF(HIGH_HALF)
  ) wave_i (
    .clk         (clk),
    .rst         (rst),
    .en          (siren_on),
    .tone_req    (tone_req),
    .tone_out    (tone_out),
    .tone_active (tone_active)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(siren_on) |-> (tone_active == TONE_LOW && tone_req == TONE_LOW)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !tone_out); // R1

endmodule

// File: tb/siren_tone_gen_tb.sv
module siren_tone_gen_tb_top;

  localparam int unsigned CLK_HZ = 40;
  localparam int unsigned LO_HZ  = 4;
  localparam int unsigned HI_HZ  = 6;
  localparam int unsigned DWELL  = 2;
  // R7: nearest-integer half periods, worked out independently: 40/8=5, 40/12=3.33 -> 3
  localparam int LO_N = 5;
  localparam int HI_N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic siren_on = 1'b0;
  logic sec_tick = 1'b0;
  logic tone_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model state
  int cyc = 0;
  bit prev_on = 1'b0;
  bit prev_out = 1'b0;
  int ticks = 0;
  int last_edge = 0;
  int bnd_tone = 0;
  bit first_half = 1'b0;

  always #2.5 clk = ~clk;

  siren_tone_gen #(
    .CLK_HZ(CLK_HZ), .LOW_HZ(LO_HZ), .HIGH_HZ(HI_HZ), .DWELL_SECS(DWELL)
  ) dut_i (
    .clk(clk), .rst(rst), .siren_on(siren_on), .sec_tick(sec_tick), .tone_out(tone_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int half_of(input int t);
    return (t != 0) ? HI_N : LO_N;
  endfunction

  task automatic step(input bit on, input bit tick);
    int tb4;
    int iv;
    @(negedge clk);
    siren_on = on;
    sec_tick = tick;
    @(posedge clk);
    #1;
    cyc++;
    if (on) begin
      if (!prev_on) begin
        ticks = 0;
        last_edge = cyc - 1;
        bnd_tone = 0;
        first_half = 1'b1;
      end
      tb4 = ticks;
      iv = cyc - last_edge;
      if (tone_out != prev_out) begin
        if (first_half) check(iv == LO_N, "R3", iv, LO_N);
        else check(iv == half_of(bnd_tone), "R4", iv, half_of(bnd_tone));
        bnd_tone = (tb4 / DWELL) % 2;   // R5: flip every DWELL accepted pulses
        last_edge = cyc;
        first_half = 1'b0;
      end else begin
        // R6: no transition before the current half period is complete
        check(iv < half_of(bnd_tone), "R6", iv, half_of(bnd_tone));
      end
      if (tick) ticks++;
    end else begin
      check(tone_out == 1'b0, "R2", int'(tone_out), 0);
    end
    prev_out = tone_out;
    prev_on = on;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    siren_on = 1'b0;
    sec_tick = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(tone_out == 1'b0, "R1", int'(tone_out), 0);
    @(negedge clk);
    rst = 1'b0;
    prev_on = 1'b0;
    prev_out = 1'b0;
  endtask

  initial begin
    do_reset();
    // R2: idle with pulses, then activation must start clean
    for (int i = 0; i < 9; i++) step(1'b0, (i % 2) == 0);
    // R3/R4: long run with no pulses stays on the low tone
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    // R5/R6: sweep pulse spacing and run length
    for (int tp = 1; tp <= 7; tp++) begin
      for (int rl = 0; rl < 2; rl++) begin
        for (int i = 0; i < 30 + 31 * rl; i++) step(1'b1, (i % tp) == (tp - 1));
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      end
    end
    // R5: odd pulse count before a disable must not carry over
    step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    // R1: reset in mid-tone
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < 25; i++) step(1'b1, (i % 4) == 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule